// File: doc/BRIEF.md
# Checkpointed Register Alias Table

This block tracks, for every architectural register of an out-of-order core, whether a younger in-flight instruction will produce its value and, if so, which reorder-buffer tag that producer holds. Two independent 32-entry maps are kept: one for integer registers and one for floating-point registers. Dispatch reads source mappings through combinational lookup ports and writes a destination mapping every time it renames an instruction. Retirement clears a mapping only while the entry still points at the tag that is retiring.

When a branch is dispatched, the block saves both maps and the current return-address-stack pointer into one of four snapshot slots. A branch that resolves correctly releases its slot. On a misprediction, the branch's slot is copied back into both live maps in a single cycle. The saved stack pointer is presented on an output, and that slot plus every slot taken after it are released. A full flush clears every mapping and releases every slot.

Top module: `rename_map_ckpt`

## Requirements
- R1: After reset, every lookup reports not renamed with tag 0, `ckptFull` is 0 and `ckptAllocId` is 0.
- R2: A rename write of register r with tag t is visible on the lookups of the same table from the next cycle on (renamed=1, tag=t). The integer and floating-point tables never affect each other. A lookup of an entry that is not renamed returns tag 0.
- R3: Integer register 0 is never renamed: a rename write to it is dropped, and a lookup of it always reports not renamed.
- R4: A commit of (table, register, tag) clears that entry's renamed flag only when the stored tag equals the committing tag. Otherwise the entry is unchanged.
- R5: When a rename write and a matching commit hit the same entry in the same cycle, the rename wins and the entry shows the new tag.
- R6: `ckptAllocId` shows the lowest-numbered free slot (0..3). An accepted allocation stores both maps as they are after that cycle's renames and commits, together with `ckptRasPtr`.
- R7: `ckptFull` is 1 exactly when all four slots are in use. An allocation request while full is ignored.
- R8: During a cycle with `restoreEn`, `restoredRasPtr` shows the stack pointer saved in slot `restoreId`. From the next cycle on, both live maps equal that slot's contents. Rename writes in the restore cycle are dropped.
- R9: A restore releases slot `restoreId` and every slot allocated after it. Slots allocated before it stay in use.
- R10: `branchOkEn` releases slot `branchOkId`.
- R11: A commit also clears the matching entry, under the same tag-equality rule, in every saved slot.
- R12: `flushAll` clears every renamed flag in both live maps and releases every slot. It overrides a restore, an allocation or a rename in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flushAll | input | 1 | Clear all mappings and release all slots |
| intRenEn | input | 1 | Integer rename write strobe |
| intRenReg | input | 5 | Integer destination register |
| intRenTag | input | 5 | Tag assigned to integer destination |
| fpRenEn | input | 1 | FP rename write strobe |
| fpRenReg | input | 5 | FP destination register |
| fpRenTag | input | 5 | Tag assigned to FP destination |
| commitEn | input | 1 | Commit strobe |
| commitIsFp | input | 1 | Commit targets FP table when 1 |
| commitReg | input | 5 | Committing destination register |
| commitTag | input | 5 | Committing tag |
| intSrcReg | input | 2x5 | Integer lookup register indices |
| intSrcRenamed | output | 2 | Integer lookup renamed flags |
| intSrcTag | output | 2x5 | Integer lookup tags (0 when not renamed) |
| fpSrcReg | input | 2x5 | FP lookup register indices |
| fpSrcRenamed | output | 2 | FP lookup renamed flags |
| fpSrcTag | output | 2x5 | FP lookup tags (0 when not renamed) |
| ckptAllocEn | input | 1 | Allocate a snapshot slot (branch dispatch) |
| ckptRasPtr | input | 4 | Stack pointer to store with the snapshot |
| ckptAllocId | output | 2 | Slot the next allocation will take |
| ckptFull | output | 1 | All slots in use; dispatch must stall branches |
| branchOkEn | input | 1 | Branch resolved correctly |
| branchOkId | input | 2 | Slot to release |
| restoreEn | input | 1 | Misprediction restore strobe |
| restoreId | input | 2 | Slot to restore |
| restoredRasPtr | output | 4 | Stack pointer saved in slot `restoreId` |

## Verification
A corrupted live entry shows up on the very next lookup of that register. It appears as a wrong renamed flag or tag, one cycle after the faulty write. A corrupted snapshot stays hidden until its slot is restored, so the bench restores slots whose contents were changed after saving, both by later renames and by commits, and reads back many registers. Errors in the slot bookkeeping appear on `ckptAllocId` and `ckptFull` one cycle after an allocate, release, restore or flush, so these are checked after each such event.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
  localparam int CkptCount = 4;
  localparam int CkIdxW    = $clog2(CkptCount);

  typedef struct packed {
    logic              flush;
    logic              restore;
    logic [CkIdxW-1:0] restoreSlot;
    logic              alloc;
    logic [CkIdxW-1:0] allocSlot;
  } ckptStrobe_t;
endpackage

// File: rtl/rmap_ctrl.sv
module rmap_ctrl
  import rmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flushAll,
  input  logic              allocReq,
  input  logic              branchOk,
  input  logic [CkIdxW-1:0] branchOkSlot,
  input  logic              restoreReq,
  input  logic [CkIdxW-1:0] restoreSlot,
  output ckptStrobe_t       strb,
  output logic [CkIdxW-1:0] freeSlot,
  output logic              ckptFull
);
  logic [CkptCount-1:0] slotBusy, busyNxt;
  // younger[i][j] = 1 : slot j was taken after slot i
  logic [CkptCount-1:0][CkptCount-1:0] younger, youngerNxt;
  logic anyFree;

  always_comb begin
    freeSlot = '0;
    anyFree  = 1'b0;
    for (int i = CkptCount - 1; i >= 0; i--) begin
      if (!slotBusy[i]) begin
        freeSlot = CkIdxW'(i);
        anyFree  = 1'b1;
      end
    end
  end

  assign ckptFull         = !anyFree;
  assign strb.flush       = flushAll;
  assign strb.restore     = restoreReq && !flushAll;
  assign strb.restoreSlot = restoreSlot;
  assign strb.alloc       = allocReq && anyFree && !flushAll && !restoreReq;
  assign strb.allocSlot   = freeSlot;

  always_comb begin
    busyNxt    = slotBusy;
    youngerNxt = younger;
    if (branchOk) busyNxt[branchOkSlot] = 1'b0;
    if (strb.restore) begin
      for (int k = 0; k < CkptCount; k++) begin
        if (CkIdxW'(k) == restoreSlot || younger[restoreSlot][k]) busyNxt[k] = 1'b0;
      end
    end
    if (strb.alloc) begin
      busyNxt[freeSlot]    = 1'b1;
      youngerNxt[freeSlot] = '0;
      for (int i = 0; i < CkptCount; i++) youngerNxt[i][freeSlot] = slotBusy[i];
    end
    if (flushAll) busyNxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slotBusy <= '0;
      younger  <= '0;
    end else begin
      slotBusy <= busyNxt;
      younger  <= youngerNxt;
    end
  end

  // R12
  flush_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flushAll |=> (slotBusy == '0));
  // R9
  restore_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.restore |=> !slotBusy[$past(restoreSlot)]);
  // R6
  alloc_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (allocReq && !ckptFull && !flushAll && !restoreReq) |=> slotBusy[$past(freeSlot)]);
  // R10
  branch_ok_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (branchOk && slotBusy[branchOkSlot] && !flushAll) |=> !slotBusy[$past(branchOkSlot)]);
endmodule

// File: rtl/rmap_data.sv
module rmap_data
  import rmap_pkg::*;
#(
  parameter int NumRegs = 32,
  parameter int TagW    = 5,
  parameter int RasW    = 4,
  parameter int IntSrcs = 2,
  parameter int FpSrcs  = 2,
  localparam int RegW   = $clog2(NumRegs)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  ckptStrobe_t                    strb,
  input  logic                           intRenEn,
  input  logic [RegW-1:0]                intRenReg,
  input  logic [TagW-1:0]                intRenTag,
  input  logic                           fpRenEn,
  input  logic [RegW-1:0]                fpRenReg,
  input  logic [TagW-1:0]                fpRenTag,
  input  logic                           commitEn,
  input  logic                           commitIsFp,
  input  logic [RegW-1:0]                commitReg,
  input  logic [TagW-1:0]                commitTag,
  input  logic [RasW-1:0]                rasIn,
  input  logic [IntSrcs-1:0][RegW-1:0]   intSrcReg,
  output logic [IntSrcs-1:0]             intSrcRenamed,
  output logic [IntSrcs-1:0][TagW-1:0]   intSrcTag,
  input  logic [FpSrcs-1:0][RegW-1:0]    fpSrcReg,
  output logic [FpSrcs-1:0]              fpSrcRenamed,
  output logic [FpSrcs-1:0][TagW-1:0]    fpSrcTag,
  output logic [RasW-1:0]                restoredRas
);
  typedef logic [NumRegs-1:0]           renVec_t;
  typedef logic [NumRegs-1:0][TagW-1:0] tagVec_t;

  renVec_t intRen, intRenN, fpRen, fpRenN;
  tagVec_t intTag, intTagN, fpTag, fpTagN;
  renVec_t [CkptCount-1:0] ckIntRen, ckIntRenN, ckFpRen, ckFpRenN;
  tagVec_t [CkptCount-1:0] ckIntTag, ckIntTagN, ckFpTag, ckFpTagN;
  logic [CkptCount-1:0][RasW-1:0] ckRas, ckRasN;

  logic intCommit, fpCommit;
  assign intCommit = commitEn && !commitIsFp;
  assign fpCommit  = commitEn && commitIsFp;

  // live maps: base (restore or hold) -> commit clear -> rename -> flush
  always_comb begin
    intRenN = intRen;
    intTagN = intTag;
    fpRenN  = fpRen;
    fpTagN  = fpTag;
    if (strb.restore) begin
      intRenN = ckIntRen[strb.restoreSlot];
      intTagN = ckIntTag[strb.restoreSlot];
      fpRenN  = ckFpRen[strb.restoreSlot];
      fpTagN  = ckFpTag[strb.restoreSlot];
    end
    if (intCommit && intTagN[commitReg] == commitTag) intRenN[commitReg] = 1'b0;
    if (fpCommit && fpTagN[commitReg] == commitTag) fpRenN[commitReg] = 1'b0;
    if (!strb.restore) begin
      if (intRenEn && intRenReg != '0) begin
        intRenN[intRenReg] = 1'b1;
        intTagN[intRenReg] = intRenTag;
      end
      if (fpRenEn) begin
        fpRenN[fpRenReg] = 1'b1;
        fpTagN[fpRenReg] = fpRenTag;
      end
    end
    if (strb.flush) begin
      intRenN = '0;
      fpRenN  = '0;
    end
  end

  // snapshot slots
  always_comb begin
    ckIntRenN = ckIntRen;
    ckIntTagN = ckIntTag;
    ckFpRenN  = ckFpRen;
    ckFpTagN  = ckFpTag;
    ckRasN    = ckRas;
    for (int k = 0; k < CkptCount; k++) begin
      if (intCommit && ckIntTag[k][commitReg] == commitTag) ckIntRenN[k][commitReg] = 1'b0;
      if (fpCommit && ckFpTag[k][commitReg] == commitTag) ckFpRenN[k][commitReg] = 1'b0;
      if (strb.alloc && strb.allocSlot == CkIdxW'(k)) begin
        ckIntRenN[k] = intRenN;
        ckIntTagN[k] = intTagN;
        ckFpRenN[k]  = fpRenN;
        ckFpTagN[k]  = fpTagN;
        ckRasN[k]    = rasIn;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intRen   <= '0;
      intTag   <= '0;
      fpRen    <= '0;
      fpTag    <= '0;
      ckIntRen <= '0;
      ckIntTag <= '0;
      ckFpRen  <= '0;
      ckFpTag  <= '0;
      ckRas    <= '0;
    end else begin
      intRen   <= intRenN;
      intTag   <= intTagN;
      fpRen    <= fpRenN;
      fpTag    <= fpTagN;
      ckIntRen <= ckIntRenN;
      ckIntTag <= ckIntTagN;
      ckFpRen  <= ckFpRenN;
      ckFpTag  <= ckFpTagN;
      ckRas    <= ckRasN;
    end
  end

  assign restoredRas = ckRas[strb.restoreSlot];

  for (genvar i = 0; i < IntSrcs; i++) begin : g_intLook
    assign intSrcRenamed[i] = intRen[intSrcReg[i]];
    assign intSrcTag[i]     = intRen[intSrcReg[i]] ? intTag[intSrcReg[i]] : '0;
    // R3
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (intSrcReg[i] == '0) |-> !intSrcRenamed[i]);
  end

  for (genvar i = 0; i < FpSrcs; i++) begin : g_fpLook
    assign fpSrcRenamed[i] = fpRen[fpSrcReg[i]];
    assign fpSrcTag[i]     = fpRen[fpSrcReg[i]] ? fpTag[fpSrcReg[i]] : '0;
  end

  // R2
  rename_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (intRenEn && intRenReg != '0 && !strb.restore && !strb.flush)
      |=> (intRen[$past(intRenReg)] && intTag[$past(intRenReg)] == $past(intRenTag)));
  // R8
  restore_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.restore && !commitEn) |=> (intRen == $past(ckIntRen[strb.restoreSlot])
                                     && fpRen == $past(ckFpRen[strb.restoreSlot])));

  for (genvar k = 0; k < CkptCount; k++) begin : g_ckChk
    // R11
    ckpt_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (intCommit && !(strb.alloc && strb.allocSlot == CkIdxW'(k))
       && ckIntTag[k][commitReg] == commitTag) |=> !ckIntRen[k][$past(commitReg)]);
  end
endmodule

// File: rtl/rename_map_ckpt.sv
module rename_map_ckpt
  import rmap_pkg::*;
#(
  parameter int NUM_REGS  = 32,
  parameter int TAG_W     = 5,
  parameter int RAS_W     = 4,
  parameter int INT_SRCS  = 2,
  parameter int FP_SRCS   = 2,
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flushAll,
  input  logic                          intRenEn,
  input  logic [REG_W-1:0]              intRenReg,
  input  logic [TAG_W-1:0]              intRenTag,
  input  logic                          fpRenEn,
  input  logic [REG_W-1:0]              fpRenReg,
  input  logic [TAG_W-1:0]              fpRenTag,
  input  logic                          commitEn,
  input  logic                          commitIsFp,
  input  logic [REG_W-1:0]              commitReg,
  input  logic [TAG_W-1:0]              commitTag,
  input  logic [INT_SRCS-1:0][REG_W-1:0] intSrcReg,
  output logic [INT_SRCS-1:0]           intSrcRenamed,
  output logic [INT_SRCS-1:0][TAG_W-1:0] intSrcTag,
  input  logic [FP_SRCS-1:0][REG_W-1:0] fpSrcReg,
  output logic [FP_SRCS-1:0]            fpSrcRenamed,
  output logic [FP_SRCS-1:0][TAG_W-1:0] fpSrcTag,
  input  logic                          ckptAllocEn,
  input  logic [RAS_W-1:0]              ckptRasPtr,
  output logic [CkIdxW-1:0]             ckptAllocId,
  output logic                          ckptFull,
  input  logic                          branchOkEn,
  input  logic [CkIdxW-1:0]             branchOkId,
  input  logic                          restoreEn,
  input  logic [CkIdxW-1:0]             restoreId,
  output logic [RAS_W-1:0]              restoredRasPtr
);
  ckptStrobe_t strb;

  rmap_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .flushAll(flushAll), .allocReq(ckptAllocEn),
    .branchOk(branchOkEn), .branchOkSlot(branchOkId), .restoreReq(restoreEn),
    .restoreSlot(restoreId), .strb(strb), .freeSlot(ckptAllocId), .ckptFull(ckptFull)
  );

  rmap_data #(
    .NumRegs(NUM_REGS), .TagW(TAG_W), .RasW(RAS_W), .IntSrcs(INT_SRCS), .FpSrcs(FP_SRCS)
  ) data_i (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .intRenEn(intRenEn), .intRenReg(intRenReg), .intRenTag(intRenTag),
    .fpRenEn(fpRenEn), .fpRenReg(fpRenReg), .fpRenTag(fpRenTag),
    .commitEn(commitEn), .commitIsFp(commitIsFp), .commitReg(commitReg),
    .commitTag(commitTag), .rasIn(ckptRasPtr),
    .intSrcReg(intSrcReg), .intSrcRenamed(intSrcRenamed), .intSrcTag(intSrcTag),
    .fpSrcReg(fpSrcReg), .fpSrcRenamed(fpSrcRenamed), .fpSrcTag(fpSrcTag),
    .restoredRas(restoredRasPtr)
  );
endmodule

// File: tb/rename_map_ckpt_tb_top.sv
`timescale 1ns/1ps
module rename_map_ckpt_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic flushAll, intRenEn, fpRenEn, commitEn, commitIsFp;
  logic [4:0] intRenReg, intRenTag, fpRenReg, fpRenTag, commitReg, commitTag;
  logic [1:0][4:0] intSrcReg, intSrcTag, fpSrcReg, fpSrcTag;
  logic [1:0] intSrcRenamed, fpSrcRenamed;
  logic ckptAllocEn, ckptFull, branchOkEn, restoreEn;
  logic [3:0] ckptRasPtr, restoredRasPtr;
  logic [1:0] ckptAllocId, branchOkId, restoreId;

  int checks = 0;
  int fails = 0;

  rename_map_ckpt dut_i (.*);

  typedef struct packed {
    logic       ren;
    logic [4:0] rreg;
    logic [4:0] rtag;
    logic       cm;
    logic [4:0] creg;
    logic [4:0] ctag;
    logic [4:0] lreg;
    logic       eren;
    logic [4:0] etag;
  } vec_t;

  // integer-table vectors; state accumulates from one to the next
  localparam vec_t Vecs [0:7] = '{
    '{1'b1, 5'd3,  5'd7,  1'b0, 5'd0, 5'd0, 5'd3,  1'b1, 5'd7 },  // R2
    '{1'b1, 5'd0,  5'd9,  1'b0, 5'd0, 5'd0, 5'd0,  1'b0, 5'd0 },  // R3
    '{1'b0, 5'd0,  5'd0,  1'b1, 5'd3, 5'd5, 5'd3,  1'b1, 5'd7 },  // R4 mismatch
    '{1'b0, 5'd0,  5'd0,  1'b1, 5'd3, 5'd7, 5'd3,  1'b0, 5'd0 },  // R4 match
    '{1'b1, 5'd5,  5'd1,  1'b0, 5'd0, 5'd0, 5'd5,  1'b1, 5'd1 },  // R2
    '{1'b1, 5'd5,  5'd2,  1'b1, 5'd5, 5'd1, 5'd5,  1'b1, 5'd2 },  // R5
    '{1'b1, 5'd5,  5'd3,  1'b1, 5'd5, 5'd2, 5'd5,  1'b1, 5'd3 },  // R5
    '{1'b1, 5'd31, 5'd31, 1'b0, 5'd0, 5'd0, 5'd31, 1'b1, 5'd31}   // R2
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    flushAll = 0; intRenEn = 0; fpRenEn = 0; commitEn = 0; commitIsFp = 0;
    ckptAllocEn = 0; branchOkEn = 0; restoreEn = 0;
  endtask

  task automatic cycle();
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic lookInt(input string req, input logic [4:0] r, input int eRen, input int eTag);
    intSrcReg[1] = r;
    #0.2;
    chk(req, intSrcRenamed[1], eRen);
    chk(req, intSrcTag[1], eTag);
  endtask

  task automatic lookFp(input string req, input logic [4:0] r, input int eRen, input int eTag);
    fpSrcReg[0] = r;
    #0.2;
    chk(req, fpSrcRenamed[0], eRen);
    chk(req, fpSrcTag[0], eTag);
  endtask

  task automatic renInt(input logic [4:0] r, input logic [4:0] t);
    intRenEn = 1; intRenReg = r; intRenTag = t;
  endtask

  task automatic renFp(input logic [4:0] r, input logic [4:0] t);
    fpRenEn = 1; fpRenReg = r; fpRenTag = t;
  endtask

  task automatic alloc(input logic [3:0] ras);
    ckptAllocEn = 1; ckptRasPtr = ras;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle();
    intRenReg = 0; intRenTag = 0; fpRenReg = 0; fpRenTag = 0;
    commitReg = 0; commitTag = 0; ckptRasPtr = 0; branchOkId = 0; restoreId = 0;
    intSrcReg = '0; fpSrcReg = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    intSrcReg[0] = 5'd5;
    lookInt("R1", 5'd3, 0, 0);
    lookFp("R1", 5'd5, 0, 0);
    chk("R1", intSrcRenamed[0], 0);
    chk("R1", ckptFull, 0);
    chk("R1", ckptAllocId, 0);

    // vector walk over the integer table
    foreach (Vecs[i]) begin
      intRenEn = Vecs[i].ren; intRenReg = Vecs[i].rreg; intRenTag = Vecs[i].rtag;
      commitEn = Vecs[i].cm; commitReg = Vecs[i].creg; commitTag = Vecs[i].ctag;
      commitIsFp = 0;
      cycle();
      lookInt($sformatf("R2-5 vec%0d", i), Vecs[i].lreg, Vecs[i].eren, Vecs[i].etag);
    end

    // R2 tables independent: f3 untouched by integer renames
    lookFp("R2", 5'd3, 0, 0);
    // R4 fp commit must not clear integer r31
    commitEn = 1; commitIsFp = 1; commitReg = 5'd31; commitTag = 5'd31;
    cycle();
    lookInt("R4", 5'd31, 1, 31);

    // clean start for snapshot tests
    flushAll = 1;
    cycle();
    lookInt("R12", 5'd5, 0, 0);

    renInt(5'd1, 5'd1); renFp(5'd3, 5'd4);
    cycle();
    alloc(4'd2); renInt(5'd2, 5'd2);            // slot 0, includes r2
    cycle();
    chk("R6", ckptAllocId, 1);
    renInt(5'd1, 5'd10); renFp(5'd3, 5'd12);
    cycle();
    alloc(4'd3);                                // slot 1
    cycle();
    renInt(5'd4, 5'd11);
    cycle();
    alloc(4'd5);                                // slot 2
    cycle();
    chk("R6", ckptAllocId, 3);
    alloc(4'd6);                                // slot 3
    cycle();
    chk("R7", ckptFull, 1);
    alloc(4'd7);                                // ignored
    cycle();
    chk("R7", ckptFull, 1);
    branchOkEn = 1; branchOkId = 2'd3;
    cycle();
    chk("R10", ckptFull, 0);
    chk("R10", ckptAllocId, 3);
    commitEn = 1; commitIsFp = 0; commitReg = 5'd2; commitTag = 5'd2;
    cycle();
    lookInt("R4", 5'd2, 0, 0);
    lookInt("R2", 5'd1, 1, 10);

    restoreEn = 1; restoreId = 2'd0; renInt(5'd6, 5'd9);
    #0.2;
    chk("R8", restoredRasPtr, 2);
    cycle();
    lookInt("R8", 5'd1, 1, 1);
    lookInt("R11", 5'd2, 0, 0);
    lookInt("R8", 5'd4, 0, 0);
    lookInt("R8", 5'd6, 0, 0);
    lookFp("R8", 5'd3, 1, 4);
    chk("R9", ckptAllocId, 0);
    chk("R9", ckptFull, 0);

    // R9: older slot survives a restore of a younger one
    alloc(4'd1);  cycle();                      // slot 0
    alloc(4'd8);  cycle();                      // slot 1
    alloc(4'd9);  cycle();                      // slot 2
    restoreEn = 1; restoreId = 2'd1;
    #0.2;
    chk("R8", restoredRasPtr, 8);
    cycle();
    chk("R9", ckptAllocId, 1);
    chk("R9", ckptFull, 0);

    // R12 flush overrides allocation and clears both maps
    renInt(5'd7, 5'd3);
    cycle();
    lookInt("R2", 5'd7, 1, 3);
    flushAll = 1; alloc(4'd4); renInt(5'd8, 5'd6);
    cycle();
    lookInt("R12", 5'd7, 0, 0);
    lookInt("R12", 5'd8, 0, 0);
    lookFp("R12", 5'd3, 0, 0);
    chk("R12", ckptAllocId, 0);
    chk("R12", ckptFull, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule